// File: doc/BRIEF.md
# External Pin Interrupt Sensing Unit

This block watches seven external interrupt pins, numbered 1 to 7, and turns their activity into one interrupt request per pin for the interrupt controller. Slot 0 of every per-pin vector is reserved. Each pin has a 2-bit sense field. The field selects one of four modes: level sensing (active low), rising edge, falling edge or both edges. Every pin input passes through a two-stage synchronizer. Edges are found by comparing the synchronized value with the value one cycle older. Detected edges latch into a flag register, and software acknowledges a flag by writing 1 to it.

Software reaches the unit through a simple register bus with four 16-bit words. Each word has two byte lanes, and each lane has its own write strobe. A direction register makes a pin an input (0) or an output (1). An output pin drives the value held in a small data register and never interrupts. An enable register gates each pin's request. In level mode the request follows the synchronized pin directly and the flag plays no part. In the edge modes the request is the latched flag qualified by the enable bit.

Top module: `xpin_irq_unit`

## Requirements
- R1: After reset the sense, direction, enable, data and flag registers all read 0, `irq_req` and `pin_oe` are low, and the synchronized pin levels read as all ones (word 2 reads 16'hFE00).
- R2: Word 0 (`bus_addr`=0) holds the sense field of pin i in bits 2i+1:2i (00 level, 01 rising, 10 falling, 11 both). Bits 1:0 read 0 and ignore writes. A field is written only when the `bus_lane` bit of its byte is set.
- R3: In word 1, the low byte (lane 0) is direction and the high byte (lane 1) is enable, with pin i at bit i of its byte. Bit 0 of each byte reads 0. A write changes only the lanes whose `bus_lane` bit is 1.
- R4: In level mode, `irq_req[i]` is high exactly while the pin is an input, its enable bit is 1 and its synchronized level is 0. A pin value sampled at clock edge k shows in the request after edge k+1.
- R5: In rising mode, a low-to-high change on an input pin sets flag i whether or not the pin is enabled. A change sampled at edge k sets the flag at edge k+2. In the edge modes `irq_req[i]` equals flag i AND enable i.
- R6: In falling mode, a high-to-low change sets the flag. A rising change leaves it clear.
- R7: In both-edge mode, changes in either direction set the flag.
- R8: Word 3, lane 0 is the flag register (pin i at bit i). Writing 1 clears that flag and writing 0 leaves it. A write with `bus_lane[0]`=0 clears nothing.
- R9: If an edge is detected in the same cycle that a 1 is written to its flag bit, the flag stays set.
- R10: Level mode never sets a flag. Writing 1 to the flag of a level-mode pin leaves its request unchanged.
- R11: A pin whose direction bit is 1 sets no flag and raises no request. `pin_oe` equals the direction bits. `pin_dout` equals word 2, lane 0, bits 7:1.
- R12: Word 2, lane 1 reads the synchronized pin levels in bits 7:1, with the same latency as R4. Writes to that lane are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 2 | Word select (0 sense, 1 direction/enable, 2 data/level, 3 flags) |
| bus_lane | input | 2 | Byte-lane write enables (bit 0 low byte, bit 1 high byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word (combinational) |
| pin_in | input | 7 | External pin levels, indices 7:1 |
| pin_dout | output | 7 | Output data for pins configured as outputs |
| pin_oe | output | 7 | Output enable per pin (direction bits) |
| irq_req | output | 7 | Interrupt request per pin to the interrupt controller |

## Verification
Take a pin value that the clock edge k captures. It reaches the level request and the pin readback after edge k+1, and an edge it forms reaches the flag and the edge-mode request after edge k+2. Register writes and flag clears are visible right after the edge that samples the write. The bench drives all inputs on the falling edge and advances a behavioural model on each rising edge, keeping a short history of pin samples. It then compares every request, `pin_oe` and `pin_dout` bit with the model 1 ns after each falling edge, so every result is checked in the exact cycle it is due. Directed checks read the register words and probe the two-edge and three-edge latencies one cycle early and on time, including the cycle in which a flag clear and a new edge collide.

// File: rtl/xpin_pkg.sv
package xpin_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_t;

  localparam logic [1:0] WORD_SENSE = 2'd0;
  localparam logic [1:0] WORD_CTRL  = 2'd1;
  localparam logic [1:0] WORD_DATA  = 2'd2;
  localparam logic [1:0] WORD_FLAG  = 2'd3;

  // Edge qualification for one pin given its sense mode.
  function automatic logic edge_hit(sense_t mode, logic cur, logic prv);
    case (mode)
      SENSE_RISE: edge_hit = cur & ~prv;
      SENSE_FALL: edge_hit = ~cur & prv;
      SENSE_BOTH: edge_hit = cur ^ prv;
      default:    edge_hit = 1'b0;
    endcase
  endfunction

  // Active-low level request for an input pin.
  function automatic logic level_req(logic cur, logic en, logic dir);
    level_req = en & ~dir & ~cur;
  endfunction

  // Which byte lane holds a given bit of a word.
  function automatic int lane_of_bit(int bit_pos, int lane_w);
    lane_of_bit = bit_pos / lane_w;
  endfunction

endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
  parameter int NUM_PINS = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS:1]   pin_in,
  output logic [NUM_PINS:1]   sync_cur,
  output logic [NUM_PINS:1]   sync_prev
);

  logic [NUM_PINS:1] stage1_q;

  // Pins idle high, so every stage resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q  <= '1;
      sync_cur  <= '1;
      sync_prev <= '1;
    end else begin
      stage1_q  <= pin_in;
      sync_cur  <= stage1_q;
      sync_prev <= sync_cur;
    end
  end

  // R12
  sync_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_prev == $past(sync_cur));

endmodule

// File: rtl/xpin_regs.sv
module xpin_regs
  import xpin_pkg::*;
#(
  parameter int NUM_PINS = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [1:0]               bus_addr,
  input  logic [1:0]               bus_lane,
  input  logic [2*(NUM_PINS+1)-1:0] bus_wdata,
  input  logic [NUM_PINS:1]        pin_level,
  input  logic [NUM_PINS:1]        flag_q,
  output logic [NUM_PINS:1][1:0]   sense_q,
  output logic [NUM_PINS:1]        dir_q,
  output logic [NUM_PINS:1]        en_q,
  output logic [NUM_PINS:1]        dout_q,
  output logic [NUM_PINS:1]        flag_clr,
  output logic [2*(NUM_PINS+1)-1:0] bus_rdata
);

  localparam int LANE_W = NUM_PINS + 1;
  localparam int DW     = 2 * LANE_W;
  localparam int HI_LO  = LANE_W + 1;
  localparam int HI_HI  = LANE_W + NUM_PINS;

  logic wr_sense, wr_ctrl, wr_data, wr_flag;
  logic [DW-1:0] sense_flat;
  logic unused_wbits;

  assign wr_sense = bus_wr && (bus_addr == WORD_SENSE);
  assign wr_ctrl  = bus_wr && (bus_addr == WORD_CTRL);
  assign wr_data  = bus_wr && (bus_addr == WORD_DATA);
  assign wr_flag  = bus_wr && (bus_addr == WORD_FLAG);
  assign unused_wbits = ^bus_wdata[1:0];

  // One sense field per pin, each in the lane its bits fall into.
  for (genvar p = 1; p <= NUM_PINS; p++) begin : g_sense
    localparam int LO = 2 * p;
    localparam int LN = lane_of_bit(LO, LANE_W);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sense_q[p] <= 2'b00;
      else if (wr_sense && bus_lane[LN])
        sense_q[p] <= bus_wdata[LO+1:LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      en_q   <= '0;
      dout_q <= '0;
    end else begin
      if (wr_ctrl && bus_lane[0]) dir_q  <= bus_wdata[NUM_PINS:1];
      if (wr_ctrl && bus_lane[1]) en_q   <= bus_wdata[HI_HI:HI_LO];
      if (wr_data && bus_lane[0]) dout_q <= bus_wdata[NUM_PINS:1];
    end
  end

  assign flag_clr = (wr_flag && bus_lane[0]) ? bus_wdata[NUM_PINS:1] : '0;

  always_comb begin
    sense_flat = '0;
    for (int p = 1; p <= NUM_PINS; p++) sense_flat[2*p +: 2] = sense_q[p];
  end

  always_comb begin
    case (bus_addr)
      WORD_SENSE: bus_rdata = sense_flat;
      WORD_CTRL:  bus_rdata = {en_q, 1'b0, dir_q, 1'b0};
      WORD_DATA:  bus_rdata = {pin_level, 1'b0, dout_q, 1'b0};
      default:    bus_rdata = {{LANE_W{1'b0}}, flag_q, 1'b0};
    endcase
  end

  // R3
  ctrl_lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == WORD_CTRL && !bus_lane[1]) |=> $stable(en_q));

  // R12
  level_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == WORD_DATA && bus_lane[0] == 1'b0) |=> $stable(dout_q));

endmodule

// File: rtl/xpin_detect.sv
module xpin_detect
  import xpin_pkg::*;
#(
  parameter int NUM_PINS = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PINS:1][1:0] sense_q,
  input  logic [NUM_PINS:1]      dir_q,
  input  logic [NUM_PINS:1]      en_q,
  input  logic [NUM_PINS:1]      sync_cur,
  input  logic [NUM_PINS:1]      sync_prev,
  input  logic [NUM_PINS:1]      flag_clr,
  output logic [NUM_PINS:1]      flag_q,
  output logic [NUM_PINS:1]      irq_req
);

  logic [NUM_PINS:1] edge_evt;

  for (genvar p = 1; p <= NUM_PINS; p++) begin : g_pin
    sense_t mode_w;
    assign mode_w = sense_t'(sense_q[p]);

    // Only input pins may produce events.
    assign edge_evt[p] = ~dir_q[p] & edge_hit(mode_w, sync_cur[p], sync_prev[p]);

    // A new event outranks a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[p] <= 1'b0;
      else        flag_q[p] <= (flag_q[p] & ~flag_clr[p]) | edge_evt[p];
    end

    assign irq_req[p] = (mode_w == SENSE_LEVEL)
                      ? level_req(sync_cur[p], en_q[p], dir_q[p])
                      : (flag_q[p] & en_q[p] & ~dir_q[p]);

    // R9
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[p] |=> flag_q[p]);

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[p] && !edge_evt[p]) |=> !flag_q[p]);

    // R10
    level_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w == SENSE_LEVEL && !flag_q[p]) |=> !flag_q[p]);

    // R11
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q[p] |-> !irq_req[p]);
  end

endmodule

// File: rtl/xpin_irq_unit.sv
module xpin_irq_unit
  import xpin_pkg::*;
#(
  parameter int NUM_PINS = 7,
  localparam int DW      = 2 * (NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [1:0]          bus_lane,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NUM_PINS:1]   pin_in,
  output logic [NUM_PINS:1]   pin_dout,
  output logic [NUM_PINS:1]   pin_oe,
  output logic [NUM_PINS:1]   irq_req
);

  logic [NUM_PINS:1]      sync_cur, sync_prev;
  logic [NUM_PINS:1][1:0] sense_q;
  logic [NUM_PINS:1]      dir_q, en_q, dout_q, flag_clr, flag_q;

  xpin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .sync_cur  (sync_cur),
    .sync_prev (sync_prev)
  );

  xpin_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_lane  (bus_lane),
    .bus_wdata (bus_wdata),
    .pin_level (sync_cur),
    .flag_q    (flag_q),
    .sense_q   (sense_q),
    .dir_q     (dir_q),
    .en_q      (en_q),
    .dout_q    (dout_q),
    .flag_clr  (flag_clr),
    .bus_rdata (bus_rdata)
  );

  xpin_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .sense_q   (sense_q),
    .dir_q     (dir_q),
    .en_q      (en_q),
    .sync_cur  (sync_cur),
    .sync_prev (sync_prev),
    .flag_clr  (flag_clr),
    .flag_q    (flag_q),
    .irq_req   (irq_req)
  );

  assign pin_oe   = dir_q;
  assign pin_dout = dout_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_req == '0 && pin_oe == '0));

endmodule

// File: tb/xpin_irq_unit_bench.sv
`timescale 1ns/1ps
module xpin_irq_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [1:0]  bus_lane = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [7:1]  pin_in = '1;
  wire  [15:0] bus_rdata;
  wire  [7:1]  pin_dout, pin_oe, irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xpin_irq_unit u_xpin_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_lane(bus_lane), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_dout(pin_dout), .pin_oe(pin_oe), .irq_req(irq_req)
  );

  // Behavioural reference: pin sample history plus register contents.
  logic [7:0] m_dir, m_en, m_dout, m_flag;
  logic [1:0] m_mode [1:7];
  logic [7:0] hist [$];
  logic [7:0] cur_s, prv_s, nflag;

  initial hist = '{8'hFF, 8'hFF, 8'hFF};

  function automatic logic [7:0] m_level();
    return hist[hist.size()-2];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_en = 0; m_dout = 0; m_flag = 0;
      for (int i = 1; i <= 7; i++) m_mode[i] = 2'b00;
      hist = '{8'hFF, 8'hFF, 8'hFF};
    end else begin
      cur_s = hist[hist.size()-2];
      prv_s = hist[hist.size()-3];
      for (int i = 1; i <= 7; i++) begin
        bit ev, clr;
        ev = 0;
        if (!m_dir[i]) begin
          case (m_mode[i])
            2'b01: ev = (cur_s[i] == 1) && (prv_s[i] == 0);
            2'b10: ev = (cur_s[i] == 0) && (prv_s[i] == 1);
            2'b11: ev = cur_s[i] != prv_s[i];
            default: ev = 0;
          endcase
        end
        clr = bus_wr && bus_addr == 2'd3 && bus_lane[0] && bus_wdata[i];
        nflag[i] = ev ? 1'b1 : (clr ? 1'b0 : m_flag[i]);
      end
      nflag[0] = 1'b0;
      m_flag = nflag;
      if (bus_wr) begin
        case (bus_addr)
          2'd0: for (int i = 1; i <= 7; i++)
                  if (bus_lane[(2*i)/8]) m_mode[i] = bus_wdata[2*i +: 2];
          2'd1: begin
                  if (bus_lane[0]) m_dir = bus_wdata[7:0] & 8'hFE;
                  if (bus_lane[1]) m_en  = bus_wdata[15:8] & 8'hFE;
                end
          2'd2: if (bus_lane[0]) m_dout = bus_wdata[7:0] & 8'hFE;
          default: ;
        endcase
      end
      hist.push_back({pin_in, 1'b1});
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  function automatic logic m_irq(int i);
    logic [7:0] s;
    s = m_level();
    if (m_dir[i]) return 1'b0;
    if (m_mode[i] == 2'b00) return m_en[i] & ~s[i];
    return m_en[i] & m_flag[i];
  endfunction

  function automatic logic [15:0] m_word(logic [1:0] a);
    logic [15:0] w;
    w = 16'h0;
    case (a)
      2'd0: for (int i = 1; i <= 7; i++) w[2*i +: 2] = m_mode[i];
      2'd1: w = {m_en, m_dir};
      2'd2: w = {m_level() & 8'hFE, m_dout};
      default: w = {8'h00, m_flag};
    endcase
    return w;
  endfunction

  function automatic string pin_tag(int i);
    if (m_dir[i]) return "R11";
    case (m_mode[i])
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      for (int i = 1; i <= 7; i++)
        check({15'h0, irq_req[i]}, {15'h0, m_irq(i)}, pin_tag(i));
      check({9'h0, pin_oe}, {9'h0, m_dir[7:1]}, "R11 oe");
      check({9'h0, pin_dout}, {9'h0, m_dout[7:1]}, "R11 dout");
    end
  end

  task automatic wr(input logic [1:0] a, input logic [1:0] l, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_lane = l; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_lane = 2'b00;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    #2;
    v = bus_rdata;
    check(v, m_word(a), tag);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, "R1", v); check(v, 16'h0000, "R1 sense");
    rd(2'd1, "R1", v); check(v, 16'h0000, "R1 ctrl");
    rd(2'd2, "R1", v); check(v, 16'hFE00, "R1 level");
    rd(2'd3, "R1", v); check(v, 16'h0000, "R1 flag");
    check({9'h0, irq_req}, 16'h0, "R1 irq");

    // R2 sense map: p2 rise, p3 fall, p4 both, p5 rise, p6 fall, p1/p7 level
    wr(2'd0, 2'b11, 16'h2793);
    rd(2'd0, "R2", v); check(v, 16'h2790, "R2 sense");

    // R3 lane strobes
    wr(2'd1, 2'b10, 16'hFF55);
    rd(2'd1, "R3", v); check(v, 16'hFE00, "R3 lane1 only");
    wr(2'd1, 2'b01, 16'h0000);
    rd(2'd1, "R3", v); check(v, 16'hFE00, "R3 lane0 only");

    // R4 level latency on pin 7
    @(negedge clk); pin_in[7] = 1'b0;
    @(negedge clk); #1 check({15'h0, irq_req[7]}, 16'h0, "R4 early");
    @(negedge clk); #1 check({15'h0, irq_req[7]}, 16'h1, "R4 due");
    @(negedge clk); pin_in[7] = 1'b1;
    settle(3);

    // R5 rising on pin 2
    @(negedge clk); pin_in[2] = 1'b0;
    settle(4);
    pin_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk); #1 check({15'h0, irq_req[2]}, 16'h0, "R5 early");
    @(negedge clk); #1 check({15'h0, irq_req[2]}, 16'h1, "R5 due");
    rd(2'd3, "R5", v); check(v & 16'h0004, 16'h0004, "R5 flag");

    // R8 write-one-to-clear
    wr(2'd3, 2'b01, 16'h0000);
    rd(2'd3, "R8", v); check(v & 16'h0004, 16'h0004, "R8 zero keeps");
    wr(2'd3, 2'b10, 16'h00FF);
    rd(2'd3, "R8", v); check(v & 16'h0004, 16'h0004, "R8 lane gate");
    wr(2'd3, 2'b01, 16'h0004);
    rd(2'd3, "R8", v); check(v & 16'h0004, 16'h0000, "R8 cleared");

    // R6 falling on pin 3
    @(negedge clk); pin_in[3] = 1'b0;
    settle(4);
    rd(2'd3, "R6", v); check(v & 16'h0008, 16'h0008, "R6 fall sets");
    wr(2'd3, 2'b01, 16'h0008);
    @(negedge clk); pin_in[3] = 1'b1;
    settle(4);
    rd(2'd3, "R6", v); check(v & 16'h0008, 16'h0000, "R6 rise ignored");

    // R7 both edges on pin 4
    @(negedge clk); pin_in[4] = 1'b0;
    settle(4);
    rd(2'd3, "R7", v); check(v & 16'h0010, 16'h0010, "R7 fall");
    wr(2'd3, 2'b01, 16'h0010);
    @(negedge clk); pin_in[4] = 1'b1;
    settle(4);
    rd(2'd3, "R7", v); check(v & 16'h0010, 16'h0010, "R7 rise");
    wr(2'd3, 2'b01, 16'h0010);
    settle(2);

    // R9 clear collides with a new edge
    @(negedge clk); pin_in[4] = 1'b0;
    @(negedge clk);
    wr(2'd3, 2'b01, 16'h0010);
    rd(2'd3, "R9", v); check(v & 16'h0010, 16'h0010, "R9 set wins");
    wr(2'd3, 2'b01, 16'h0010);

    // R10 level pin and flag writes
    @(negedge clk); pin_in[1] = 1'b0;
    settle(4);
    rd(2'd3, "R10", v); check(v & 16'h0002, 16'h0000, "R10 no flag");
    wr(2'd3, 2'b01, 16'h0002);
    #1 check({15'h0, irq_req[1]}, 16'h1, "R10 irq kept");
    @(negedge clk); pin_in[1] = 1'b1;
    settle(3);

    // R11 output direction
    wr(2'd1, 2'b01, 16'h0020);
    @(negedge clk); pin_in[5] = 1'b0;
    settle(3);
    pin_in[5] = 1'b1;
    settle(4);
    rd(2'd3, "R11", v); check(v & 16'h0020, 16'h0000, "R11 no flag");
    wr(2'd2, 2'b01, 16'h00A5);
    #1 check({8'h0, pin_dout, 1'b0}, 16'h00A4, "R11 dout");
    check({8'h0, pin_oe, 1'b0}, 16'h0020, "R11 oe");

    // R12 pin level readback, read-only lane
    @(negedge clk); pin_in = 7'b0101011;
    settle(3);
    rd(2'd2, "R12", v); check(v & 16'hFF00, 16'h5600, "R12 level");
    wr(2'd2, 2'b10, 16'h1200);
    rd(2'd2, "R12", v); check(v, 16'h56A4, "R12 ignored");

    // Mixed stress: random pins, modes, directions and clears
    wr(2'd1, 2'b11, 16'hFE00);
    for (int n = 0; n < 800; n++) begin
      @(negedge clk);
      pin_in = 7'($urandom);
      case ($urandom % 16)
        0: wr(2'd3, 2'b01, 16'($urandom));
        1: wr(2'd0, 2'($urandom), 16'($urandom));
        2: wr(2'd1, 2'b11, 16'($urandom) | 16'hFE00);
        3: begin logic [15:0] t; rd(2'd3, "R8", t); end
        default: ;
      endcase
    end
    rd(2'd0, "R2", v);
    rd(2'd1, "R3", v);
    summary();
  end

endmodule